// File: doc/BRIEF.md
# Oldest-First Crossbar Arbiter

This block connects a set of requesters to a set of destinations through a crossbar. Every requester offers one packet per cycle, tagged with a destination index. The packet is accepted into a small queue kept for that requester and that destination. Each destination runs its own arbiter. The arbiter picks the packet that has waited longest among the heads of all queues aimed at it.

A packet passes through three stages: request (enqueue), arbitrate (winner latched) and transmit (beat driven on the destination bus). A packet is either short, which means one beat, or long, which means two beats. A long packet carries twice the bus width and is sent as two beats in consecutive cycles. The destination stays with that packet until its second beat has gone out. All destinations work independently of each other, so several transfers can run in the same cycle.

Top module: `xbar_oldest_first`

## Requirements
- R1: Each requester/destination queue holds at most two packets. `in_ready[s*ND+d]` is low exactly when two packets from requester s for destination d are waiting in that queue. Other destinations of the same requester are not affected.
- R2: A packet accepted at a clock edge into an idle destination appears on `out_valid` after the second following edge, and not earlier.
- R3: For each destination, the packet that waited longest wins. Packets accepted in the same cycle are ordered by lowest requester index. The resulting delivery order per destination equals acceptance order, with same-cycle ties broken by requester index.
- R4: A long packet (`in_long`=1) drives `in_data[DW-1:0]` as its first beat and `in_data[2*DW-1:DW]` as its second beat, in back-to-back cycles, with the same `out_src`. `out_last` is high only on the final beat. A short packet is one beat with `out_last`=1 and carries `in_data[DW-1:0]`.
- R5: Packets from one requester to one destination are delivered in the order they were accepted.
- R6: Different destinations transfer in the same cycle when each has work.
- R7: While reset is held, every `out_valid` is low and every `in_ready` is high.
- R8: Every accepted packet is delivered exactly once. No beat appears that was not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NS | Requester s offers a packet |
| in_dest | input | NS*DSW | Destination index per requester |
| in_long | input | NS | Packet is two beats |
| in_data | input | NS*2*DW | Packet payload, first beat in the low half |
| in_ready | output | NS*ND | Queue (s,d) has room, bit s*ND+d |
| out_valid | output | ND | Destination d carries a beat |
| out_last | output | ND | Beat is the last of its packet |
| out_src | output | ND*SW | Requester index of the beat |
| out_data | output | ND*DW | Beat payload |

## Verification
The assertions assume three things about the inputs. First, `in_dest` always names an existing destination. Second, inputs carry no unknown values after reset. Third, no packet waits longer than half the age-stamp range. The third point follows from the two-entry limit: at most 2*NS packets, each of at most two beats, can be ahead of any packet for a destination. The stimulus draws every destination index modulo ND and keeps all control inputs at defined values.

The random traffic runs close to saturation, so queues fill and `in_ready` drops, yet waiting times stay inside that bound.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the oldest-first crossbar.
package xbar_pkg;
    // Entries per requester/destination queue.
    localparam int QDEPTH = 2;

    // Which beat of a packet the transmit stage is driving.
    typedef enum logic {
        BEAT_FIRST  = 1'b0,
        BEAT_SECOND = 1'b1
    } beat_e;

    // Index width for n items, at least one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/xbar_src_queue.sv
`timescale 1ns/1ps
// Two-entry FIFO for one requester/destination pair.
// Stores payload, the long flag and the enqueue age stamp.
// Assumes the caller pushes only while ready is high and pops only a valid head.
module xbar_src_queue #(
    parameter int PW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_long,
    input  logic [PW-1:0] push_data,
    input  logic [AW-1:0] push_stamp,
    input  logic          pop,
    output logic          head_valid,
    output logic          head_long,
    output logic [PW-1:0] head_data,
    output logic [AW-1:0] head_stamp,
    output logic          ready
);
    import xbar_pkg::*;

    localparam int PTRW = idx_bits(QDEPTH);
    localparam int CW   = $clog2(QDEPTH + 1);

    logic [PW-1:0]     slot_data  [QDEPTH];
    logic [AW-1:0]     slot_stamp [QDEPTH];
    logic [QDEPTH-1:0] slot_long;
    logic [PTRW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]     count;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTRW'(QDEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTRW'(QDEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Slot storage; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_data[wr_ptr]  <= push_data;
            slot_stamp[wr_ptr] <= push_stamp;
            slot_long[wr_ptr]  <= push_long;
        end
    end

    // Head view and room indication.
    always_comb begin
        head_valid = (count != '0);
        head_long  = slot_long[rd_ptr];
        head_data  = slot_data[rd_ptr];
        head_stamp = slot_stamp[rd_ptr];
        ready      = (count < CW'(QDEPTH));
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == CW'(QDEPTH - 1)) |=> !ready);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop) |=> (head_valid && $stable(head_stamp)));
endmodule

// File: rtl/xbar_age_arb.sv
`timescale 1ns/1ps
// Combinational oldest-first picker for one destination.
// Age is the modular distance from each stamp to the current counter.
// Assumes no request is older than the stamp range.
// Equal ages resolve to the lowest index.
module xbar_age_arb #(
    parameter int NS = 4,
    parameter int AW = 6,
    parameter int SW = 2
) (
    input  logic [AW-1:0]    now,
    input  logic [NS-1:0]    req,
    input  logic [NS*AW-1:0] stamp,
    output logic [NS-1:0]    grant,
    output logic [SW-1:0]    grant_idx,
    output logic             any
);
    // Scan requesters and keep the strictly oldest one seen so far.
    always_comb begin
        logic [AW-1:0] best;
        logic [AW-1:0] age;
        best      = '0;
        any       = 1'b0;
        grant_idx = '0;
        for (int i = 0; i < NS; i++) begin
            age = now - stamp[i*AW +: AW];
            if (req[i] && (!any || age > best)) begin
                any       = 1'b1;
                best      = age;
                grant_idx = SW'(i);
            end
        end
        grant = any ? (NS'(1) << grant_idx) : '0;
    end
endmodule

// File: rtl/xbar_dest_port.sv
`timescale 1ns/1ps
// One destination: arbitrate stage register plus transmit stage register.
// A long packet keeps the transmit stage for two cycles.
// While it does, the arbitrate stage holds and no queue is popped.
// Assumes head_* come from the NS queues aimed at this destination.
module xbar_dest_port #(
    parameter int NS = 4,
    parameter int DW = 16,
    parameter int AW = 6,
    parameter int SW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    now,
    input  logic [NS-1:0]    head_valid,
    input  logic [NS-1:0]    head_long,
    input  logic [NS*2*DW-1:0] head_data,
    input  logic [NS*AW-1:0] head_stamp,
    output logic [NS-1:0]    pop,
    output logic             out_valid,
    output logic             out_last,
    output logic [SW-1:0]    out_src,
    output logic [DW-1:0]    out_data
);
    import xbar_pkg::*;

    localparam int PW = 2 * DW;

    logic [NS-1:0] grant;
    logic [SW-1:0] grant_idx;
    logic          grant_any;

    logic          a_valid, a_long;
    logic [SW-1:0] a_src;
    logic [PW-1:0] a_data;

    logic          x_valid, x_long;
    logic [SW-1:0] x_src;
    logic [PW-1:0] x_data;
    beat_e         x_beat;

    logic          x_hold, a_take, a_open;

    xbar_age_arb #(.NS(NS), .AW(AW), .SW(SW)) u_arb (
        .now       (now),
        .req       (head_valid),
        .stamp     (head_stamp),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (grant_any)
    );

    // Stage handshakes: the second beat locks both stages.
    always_comb begin
        x_hold = x_valid && x_long && (x_beat == BEAT_FIRST);
        a_take = a_valid && !x_hold;
        a_open = !a_valid || a_take;
        pop    = a_open ? grant : '0;
    end

    // Arbitrate stage: latch the winning head when the stage is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_long  <= 1'b0;
            a_src   <= '0;
            a_data  <= '0;
        end else if (a_open) begin
            a_valid <= grant_any;
            a_long  <= head_long[grant_idx];
            a_src   <= grant_idx;
            a_data  <= head_data[grant_idx*PW +: PW];
        end
    end

    // Transmit stage: advance to the second beat or take the next packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_valid <= 1'b0;
            x_long  <= 1'b0;
            x_src   <= '0;
            x_data  <= '0;
            x_beat  <= BEAT_FIRST;
        end else if (x_hold) begin
            x_beat  <= BEAT_SECOND;
        end else begin
            x_valid <= a_valid;
            x_long  <= a_long;
            x_src   <= a_src;
            x_data  <= a_data;
            x_beat  <= BEAT_FIRST;
        end
    end

    // Drive the destination bus from the transmit stage.
    always_comb begin
        out_valid = x_valid;
        out_last  = x_valid && (!x_long || x_beat == BEAT_SECOND);
        out_src   = x_src;
        out_data  = (x_beat == BEAT_SECOND) ? x_data[PW-1:DW] : x_data[DW-1:0];
    end

    // R3
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    // R3
    grant_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop & ~head_valid) == '0);

    // R4
    second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_last && $stable(out_src)));

    // R2
    transmit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !x_hold) |=> out_valid);

    // R3
    for (genvar i = 0; i < NS; i++) begin : g_age_win
        logic [AW-1:0] wait_age;
        assign wait_age = now - head_stamp[i*AW +: AW];
        age_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            head_valid[i] |-> (wait_age < AW'(1 << (AW - 1))));
    end
endmodule

// File: rtl/xbar_oldest_first.sv
`timescale 1ns/1ps
// Crossbar from NS requesters to ND destinations with oldest-first arbitration.
// Each (requester, destination) pair has a two-entry queue.
// Every accepted packet is stamped with a free-running counter.
// Assumes in_dest is below ND whenever in_valid is high.
module xbar_oldest_first #(
    parameter int NS  = 4,
    parameter int ND  = 4,
    parameter int DW  = 16,
    parameter int SW  = xbar_pkg::idx_bits(NS),
    parameter int DSW = xbar_pkg::idx_bits(ND)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS-1:0]        in_valid,
    input  logic [NS*DSW-1:0]    in_dest,
    input  logic [NS-1:0]        in_long,
    input  logic [NS*2*DW-1:0]   in_data,
    output logic [NS*ND-1:0]     in_ready,
    output logic [ND-1:0]        out_valid,
    output logic [ND-1:0]        out_last,
    output logic [ND*SW-1:0]     out_src,
    output logic [ND*DW-1:0]     out_data
);
    localparam int PW = 2 * DW;
    localparam int AW = $clog2(4 * NS + 8) + 1;

    logic [AW-1:0] now_q;

    // Free-running age counter used to stamp accepted packets.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    for (genvar d = 0; d < ND; d++) begin : g_dest
        logic [NS-1:0]    hv, hl, pop, push, rdy;
        logic [NS*PW-1:0] hd;
        logic [NS*AW-1:0] hs;

        for (genvar s = 0; s < NS; s++) begin : g_src
            assign push[s] = in_valid[s] && (in_dest[s*DSW +: DSW] == DSW'(d)) && rdy[s];
            assign in_ready[s*ND + d] = rdy[s];

            xbar_src_queue #(.PW(PW), .AW(AW)) u_q (
                .clk        (clk),
                .rst_n      (rst_n),
                .push       (push[s]),
                .push_long  (in_long[s]),
                .push_data  (in_data[s*PW +: PW]),
                .push_stamp (now_q),
                .pop        (pop[s]),
                .head_valid (hv[s]),
                .head_long  (hl[s]),
                .head_data  (hd[s*PW +: PW]),
                .head_stamp (hs[s*AW +: AW]),
                .ready      (rdy[s])
            );
        end

        xbar_dest_port #(.NS(NS), .DW(DW), .AW(AW), .SW(SW)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .now        (now_q),
            .head_valid (hv),
            .head_long  (hl),
            .head_data  (hd),
            .head_stamp (hs),
            .pop        (pop),
            .out_valid  (out_valid[d]),
            .out_last   (out_last[d]),
            .out_src    (out_src[d*SW +: SW]),
            .out_data   (out_data[d*DW +: DW])
        );
    end

    // R7
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));
endmodule

// File: tb/xbar_oldest_first_bench.sv
`timescale 1ns/1ps
module xbar_oldest_first_bench;
    localparam int NS  = 4;
    localparam int ND  = 4;
    localparam int DW  = 16;
    localparam int SW  = 2;
    localparam int DSW = 2;

    typedef struct packed {
        logic [7:0]      src;
        logic            lng;
        logic [2*DW-1:0] data;
    } pkt_t;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NS-1:0]       in_valid;
    logic [NS*DSW-1:0]   in_dest;
    logic [NS-1:0]       in_long;
    logic [NS*2*DW-1:0]  in_data;
    logic [NS*ND-1:0]    in_ready;
    logic [ND-1:0]       out_valid;
    logic [ND-1:0]       out_last;
    logic [ND*SW-1:0]    out_src;
    logic [ND*DW-1:0]    out_data;

    always #2.5 clk = ~clk;

    xbar_oldest_first #(.NS(NS), .ND(ND), .DW(DW)) u_xbar_oldest_first (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_long(in_long), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_last(out_last), .out_src(out_src),
        .out_data(out_data)
    );

    int   checks = 0;
    int   errors = 0;
    pkt_t exp_q [ND][$];
    logic pend  [ND];
    pkt_t held  [ND];

    logic [NS-1:0]   drv_v, drv_l;
    logic [DSW-1:0]  drv_d [NS];
    logic [2*DW-1:0] drv_x [NS];

    // Expected beat payload for beat b of packet p (R4).
    function automatic logic [DW-1:0] beat_of(input pkt_t p, input int b);
        return (b == 0) ? p.data[DW-1:0] : p.data[2*DW-1:DW];
    endfunction

    // Expected last flag for beat b of packet p (R4).
    function automatic logic last_of(input pkt_t p, input int b);
        return (!p.lng) || (b == 1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    // Scoreboard: compare every visible beat with the acceptance-ordered list.
    task automatic check_outputs();
        for (int d = 0; d < ND; d++) begin
            if (out_valid[d]) begin
                if (pend[d]) begin
                    check(out_src[d*SW +: SW] == held[d].src[SW-1:0], "R4", "second beat src",
                          64'(out_src[d*SW +: SW]), 64'(held[d].src));
                    check(out_data[d*DW +: DW] == beat_of(held[d], 1), "R4", "second beat data",
                          64'(out_data[d*DW +: DW]), 64'(beat_of(held[d], 1)));
                    check(out_last[d] == last_of(held[d], 1), "R4", "second beat last",
                          64'(out_last[d]), 64'(last_of(held[d], 1)));
                    pend[d] = 1'b0;
                end else if (exp_q[d].size() == 0) begin
                    check(1'b0, "R8", "beat with nothing accepted", 64'(out_src[d*SW +: SW]), 64'hFF);
                end else begin
                    pkt_t p;
                    p = exp_q[d].pop_front();
                    check(out_src[d*SW +: SW] == p.src[SW-1:0], "R3 R5", "winner order src",
                          64'(out_src[d*SW +: SW]), 64'(p.src));
                    check(out_data[d*DW +: DW] == beat_of(p, 0), "R4", "first beat data",
                          64'(out_data[d*DW +: DW]), 64'(beat_of(p, 0)));
                    check(out_last[d] == last_of(p, 0), "R4", "first beat last",
                          64'(out_last[d]), 64'(last_of(p, 0)));
                    if (p.lng) begin
                        pend[d] = 1'b1;
                        held[d] = p;
                    end
                end
            end else if (pend[d]) begin
                check(1'b0, "R4", "second beat missing", 64'd0, 64'd1);
                pend[d] = 1'b0;
            end
        end
    endtask

    // One cycle: drive, record accepted packets, move to next negedge, score.
    task automatic tick();
        for (int s = 0; s < NS; s++) begin
            in_valid[s]                = drv_v[s];
            in_dest[s*DSW +: DSW]      = drv_d[s];
            in_long[s]                 = drv_l[s];
            in_data[s*2*DW +: 2*DW]    = drv_x[s];
        end
        #1;
        for (int s = 0; s < NS; s++) begin
            if (drv_v[s] && in_ready[s*ND + int'(drv_d[s])])
                exp_q[int'(drv_d[s])].push_back({8'(s), drv_l[s], drv_x[s]});
        end
        @(negedge clk);
        check_outputs();
    endtask

    task automatic idle_inputs();
        drv_v = '0;
        drv_l = '0;
        for (int s = 0; s < NS; s++) begin
            drv_d[s] = '0;
            drv_x[s] = '0;
        end
    endtask

    task automatic drain();
        idle_inputs();
        repeat (40) tick();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);
        for (int d = 0; d < ND; d++) pend[d] = 1'b0;
        idle_inputs();
        in_valid = '0; in_dest = '0; in_long = '0; in_data = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R7 reset state
        check(out_valid == '0, "R7", "out_valid in reset", 64'(out_valid), 64'd0);
        check(in_ready == '1, "R7", "in_ready in reset", 64'(in_ready), 64'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R6: three destinations loaded in one cycle
        drv_v = 4'b0111; drv_l = 4'b0100;
        drv_d[0] = 2'd0; drv_d[1] = 2'd1; drv_d[2] = 2'd2;
        drv_x[0] = 32'hA0A0_0A0A; drv_x[1] = 32'hB1B1_1B1B; drv_x[2] = 32'hC2C2_2C2C;
        tick();
        idle_inputs();
        tick();
        check(out_valid[2:0] == 3'b000, "R2", "no output one edge after accept",
              64'(out_valid), 64'd0);
        tick();
        check(out_valid[2:0] == 3'b111, "R2 R6", "parallel output two edges after accept",
              64'(out_valid), 64'h7);
        tick();
        check(out_valid[2] && out_last[2] && !out_valid[0], "R4", "long packet second beat only",
              64'({out_valid[2], out_last[2], out_valid[0]}), 64'h6);
        drain();

        // R1 R3: all requesters to destination 0, two cycles in a row
        drv_v = '1; drv_l = '1;
        for (int s = 0; s < NS; s++) begin
            drv_d[s] = 2'd0;
            drv_x[s] = {16'(16'h1100 + s), 16'(16'h2200 + s)};
        end
        tick();
        check(in_ready[3*ND] && in_ready[2*ND] && in_ready[ND] && in_ready[0], "R1",
              "one entry each leaves room", 64'(in_ready), 64'h1111);
        for (int s = 0; s < NS; s++) drv_x[s] = {16'(16'h3300 + s), 16'(16'h4400 + s)};
        tick();
        check(in_ready[0] && !in_ready[ND] && !in_ready[2*ND] && !in_ready[3*ND], "R1",
              "full queues drop ready, popped one keeps it",
              64'({in_ready[3*ND], in_ready[2*ND], in_ready[ND], in_ready[0]}), 64'h1);
        check(in_ready[ND + 1] && in_ready[2*ND + 1], "R1", "other destination unaffected",
              64'({in_ready[2*ND + 1], in_ready[ND + 1]}), 64'h3);
        drain();

        // R3 R5 R8: constrained random traffic near saturation
        for (int i = 0; i < 3000; i++) begin
            for (int s = 0; s < NS; s++) begin
                drv_v[s] = ($urandom % 10) < 6;
                drv_d[s] = DSW'($urandom % ND);
                drv_l[s] = $urandom % 2;
                drv_x[s] = 32'($urandom);
            end
            tick();
        end
        drain();

        // R8 everything accepted was delivered
        for (int d = 0; d < ND; d++)
            check(exp_q[d].size() == 0 && !pend[d], "R8", "leftover packets",
                  64'(exp_q[d].size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule